// File: doc/BRIEF.md
# Advanced Load Address Check Table

This block lets a scheduler hoist a load above stores that might write the same location. When such a hoisted ("advanced") load issues, it records its destination register and its address in a small fully associative table. Every store that follows presents its address, and every entry holding a matching doubleword is cleared in one cycle. Where the load originally sat, a check for the register asks whether the entry is still valid.

A valid entry means no store touched the location, so the speculative value may be used. The check then consumes the entry. A missing entry means a store aliased the load, a newer load replaced the entry, or the entry was evicted for lack of space. In all of these cases the response asks for a redirect to recovery code that repeats the load.

The table has ENTRIES slots, 16 by default. An allocation reuses the slot already held by its register. Otherwise it takes the lowest free slot. When no slot is free, it replaces slots in rotating order. Address compares ignore the low GRAN_LSB address bits, which gives doubleword granularity by default.

Top module: `alat_table`

## Requirements
- R1: An allocation with `alloc_valid` high records `alloc_reg` and `alloc_addr`. A later check of that register, with no intervening alias, replacement or eviction, returns a hit.
- R2: A store with `store_valid` high invalidates every valid entry whose address bits [ADDR_W-1:GRAN_LSB] equal those of `store_addr`. A later check of an invalidated register returns fixup.
- R3: An allocation to a register that already has a valid entry overwrites that entry, including its address. A register never owns more than one valid entry.
- R4: The response to a check is registered and appears in the cycle after `chk_valid`. With `rsp_valid` high, exactly one of `rsp_hit` and `rsp_fixup` is high. With `rsp_valid` low, both are low.
- R5: A check of a register that has no valid entry returns `rsp_fixup`.
- R6: A check that hits removes the entry, so a second check of the same register returns fixup.
- R7: A new register takes the lowest-indexed free slot. When all slots are valid, it evicts a victim picked by a rotating pointer that starts at slot 0 and advances by one on each eviction. A check of the evicted register returns fixup.
- R8: When an allocation and a store to the same doubleword arrive in the same cycle, the allocation wins and its entry remains valid.
- R9: A check sees the table as it stood before that cycle's allocation, store and removal. A store or allocation in the same cycle does not change that check's response.
- R10: Accesses to different bytes of one doubleword conflict. A store to the adjacent doubleword leaves the entry valid.
- R11: An asynchronous active-low reset empties the table, sets the replacement pointer to slot 0 and drives all response outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Advanced load allocates an entry |
| alloc_reg | input | REG_W | Destination register of the advanced load |
| alloc_addr | input | ADDR_W | Byte address of the advanced load |
| store_valid | input | 1 | Store snoops the table |
| store_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check request |
| chk_reg | input | REG_W | Register being checked |
| rsp_valid | output | 1 | Check response present |
| rsp_hit | output | 1 | Speculation held, entry consumed |
| rsp_fixup | output | 1 | Entry missing, redirect to recovery code |

## Verification
Allocations, store invalidations and removals on a hit take effect at the clock edge where they are sampled. A check's response appears one register stage later. The bench therefore drives all inputs on the falling edge and steps its behavioural table model at the rising edge, using the state from before the edge. It then compares all three response outputs on the following falling edge, so every response is compared in the exact cycle it is due. Directed sequences add an expected hit or fixup, taken from the requirements, for the same cycle; these cover same-cycle collisions, byte aliasing inside a doubleword and rotating eviction.

// File: rtl/alat_pkg.sv
package alat_pkg;

  // Largest table the slot encoders below support.
  localparam int unsigned ALAT_MAX_ENTRIES = 64;

  // Index of the lowest set bit; 0 when no bit is set.
  function automatic int unsigned lowest_set(input logic [ALAT_MAX_ENTRIES-1:0] v);
    int unsigned r;
    r = 0;
    for (int i = ALAT_MAX_ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/alat_match.sv
// Parallel compare of every slot against the allocate, check and store keys.
module alat_match #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned REG_W   = 7,
  parameter int unsigned DW_W    = 61
) (
  input  logic [ENTRIES-1:0]            vld,
  input  logic [ENTRIES-1:0][REG_W-1:0] tag,
  input  logic [ENTRIES-1:0][DW_W-1:0]  dw,
  input  logic [REG_W-1:0]              alloc_reg,
  input  logic [REG_W-1:0]              chk_reg,
  input  logic [DW_W-1:0]               store_dw,
  output logic [ENTRIES-1:0]            alloc_vec,
  output logic [ENTRIES-1:0]            chk_vec,
  output logic [ENTRIES-1:0]            store_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign alloc_vec[g] = vld[g] && (tag[g] == alloc_reg);
    assign chk_vec[g]   = vld[g] && (tag[g] == chk_reg);
    assign store_vec[g] = vld[g] && (dw[g] == store_dw);
  end
endmodule

// File: rtl/alat_victim.sv
// Free-slot finder and rotating eviction pointer.
module alat_victim
  import alat_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] vld,
  input  logic               evict,
  output logic               free_any,
  output logic [IDX_W-1:0]   free_idx,
  output logic [IDX_W-1:0]   rr_idx
);
  logic [ALAT_MAX_ENTRIES-1:0] free_pad;
  logic [IDX_W-1:0]            rr_d;

  always_comb begin
    free_pad               = '0;
    free_pad[ENTRIES-1:0]  = ~vld;
    free_any               = |free_pad;
    free_idx               = IDX_W'(lowest_set(free_pad));
  end

  always_comb begin
    rr_d = rr_idx;
    if (evict) begin
      rr_d = (rr_idx == IDX_W'(ENTRIES - 1)) ? '0 : rr_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_idx <= '0;
    else        rr_idx <= rr_d;
  end
endmodule

// File: rtl/alat_table.sv
module alat_table
  import alat_pkg::*;
#(
  parameter int unsigned ENTRIES  = 16,
  parameter int unsigned REG_W    = 7,
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned GRAN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              store_valid,
  input  logic [ADDR_W-1:0] store_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fixup
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int unsigned DW_W  = ADDR_W - GRAN_LSB;

  logic [ENTRIES-1:0]            vld_q, vld_d;
  logic [ENTRIES-1:0][REG_W-1:0] tag_q;
  logic [ENTRIES-1:0][DW_W-1:0]  dw_q;

  logic [ENTRIES-1:0] alloc_vec, chk_vec, store_vec;
  logic               free_any, evict, alloc_same;
  logic [IDX_W-1:0]   free_idx, rr_idx, alloc_slot;
  logic [ALAT_MAX_ENTRIES-1:0] alloc_pad;
  logic               chk_found;
  logic               unused_low;

  assign unused_low = ^{alloc_addr[GRAN_LSB-1:0], store_addr[GRAN_LSB-1:0]};

  alat_match #(.ENTRIES(ENTRIES), .REG_W(REG_W), .DW_W(DW_W)) u_match (
    .vld       (vld_q),
    .tag       (tag_q),
    .dw        (dw_q),
    .alloc_reg (alloc_reg),
    .chk_reg   (chk_reg),
    .store_dw  (store_addr[ADDR_W-1:GRAN_LSB]),
    .alloc_vec (alloc_vec),
    .chk_vec   (chk_vec),
    .store_vec (store_vec)
  );

  alat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld      (vld_q),
    .evict    (evict),
    .free_any (free_any),
    .free_idx (free_idx),
    .rr_idx   (rr_idx)
  );

  // Slot choice: own slot, then lowest free slot, then rotating victim.
  always_comb begin
    alloc_pad              = '0;
    alloc_pad[ENTRIES-1:0] = alloc_vec;
    alloc_same             = |alloc_vec;
    evict                  = alloc_valid && !alloc_same && !free_any;
    if (alloc_same)    alloc_slot = IDX_W'(lowest_set(alloc_pad));
    else if (free_any) alloc_slot = free_idx;
    else               alloc_slot = rr_idx;
  end

  // Valid bits: store and consumed check clear, allocation sets last.
  always_comb begin
    chk_found = |chk_vec;
    vld_d     = vld_q;
    if (store_valid) vld_d = vld_d & ~store_vec;
    if (chk_valid)   vld_d = vld_d & ~chk_vec;
    if (alloc_valid) vld_d[alloc_slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fixup <= 1'b0;
    end else begin
      vld_q     <= vld_d;
      rsp_valid <= chk_valid;
      rsp_hit   <= chk_valid && chk_found;
      rsp_fixup <= chk_valid && !chk_found;
    end
  end

  // Payload storage, written only for the allocated slot.
  always_ff @(posedge clk) begin
    if (alloc_valid) begin
      tag_q[alloc_slot] <= alloc_reg;
      dw_q[alloc_slot]  <= alloc_addr[ADDR_W-1:GRAN_LSB];
    end
  end
endmodule

// File: rtl/alat_chk.sv
module alat_chk #(
  parameter int unsigned ENTRIES  = 16,
  parameter int unsigned REG_W    = 7,
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned GRAN_LSB = 3
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic                                    alloc_valid,
  input logic [REG_W-1:0]                        alloc_reg,
  input logic [ADDR_W-1:0]                       alloc_addr,
  input logic                                    store_valid,
  input logic [ADDR_W-1:0]                       store_addr,
  input logic                                    chk_valid,
  input logic [REG_W-1:0]                        chk_reg,
  input logic                                    rsp_valid,
  input logic                                    rsp_hit,
  input logic                                    rsp_fixup,
  input logic [ENTRIES-1:0]                      vld,
  input logic [ENTRIES-1:0][REG_W-1:0]           tag,
  input logic [ENTRIES-1:0][ADDR_W-GRAN_LSB-1:0] dw
);
  localparam int unsigned DW_W = ADDR_W - GRAN_LSB;

  logic             p_alloc, p_store;
  logic [REG_W-1:0] p_areg, p_creg;
  logic [DW_W-1:0]  p_adw, p_sdw;
  logic             dup, alloc_seen, store_left, chk_left;
  logic             unused_low;

  assign unused_low = ^{alloc_addr[GRAN_LSB-1:0], store_addr[GRAN_LSB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_alloc <= 1'b0;
      p_store <= 1'b0;
      p_areg  <= '0;
      p_creg  <= '0;
      p_adw   <= '0;
      p_sdw   <= '0;
    end else begin
      p_alloc <= alloc_valid;
      p_store <= store_valid;
      p_areg  <= alloc_reg;
      p_creg  <= chk_reg;
      p_adw   <= alloc_addr[ADDR_W-1:GRAN_LSB];
      p_sdw   <= store_addr[ADDR_W-1:GRAN_LSB];
    end
  end

  always_comb begin
    dup        = 1'b0;
    alloc_seen = 1'b0;
    store_left = 1'b0;
    chk_left   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      for (int j = i + 1; j < ENTRIES; j++) begin
        if (vld[i] && vld[j] && tag[i] == tag[j]) dup = 1'b1;
      end
      if (vld[i] && tag[i] == p_areg && dw[i] == p_adw) alloc_seen = 1'b1;
      if (vld[i] && dw[i] == p_sdw)                     store_left = 1'b1;
      if (vld[i] && tag[i] == p_creg)                   chk_left   = 1'b1;
    end
  end

  // R4
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> rsp_valid);

  // R4
  rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rsp_hit || rsp_fixup) == rsp_valid) && !(rsp_hit && rsp_fixup));

  // R3
  one_entry_per_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);

  // R1
  alloc_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_alloc |-> alloc_seen);

  // R2
  store_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_store && !(p_alloc && p_adw == p_sdw)) |-> !store_left);

  // R6
  hit_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !(p_alloc && p_areg == p_creg)) |-> !chk_left);
endmodule

bind alat_table alat_chk #(
  .ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)
) u_alat_chk (
  .clk(clk), .rst_n(rst_n),
  .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_addr(alloc_addr),
  .store_valid(store_valid), .store_addr(store_addr),
  .chk_valid(chk_valid), .chk_reg(chk_reg),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fixup(rsp_fixup),
  .vld(vld_q), .tag(tag_q), .dw(dw_q)
);

// File: tb/tb_alat_table.sv
`timescale 1ns/1ps
module tb_alat_table;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid, store_valid, chk_valid;
  logic [6:0]  alloc_reg, chk_reg;
  logic [63:0] alloc_addr, store_addr;
  logic        rsp_valid, rsp_hit, rsp_fixup;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural model of the table.
  bit              m_v [N];
  int              m_r [N];
  longint unsigned m_a [N];
  int              m_rr;

  always #2.5 clk = ~clk;

  alat_table dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_addr(alloc_addr),
    .store_valid(store_valid), .store_addr(store_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fixup(rsp_fixup)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic expect_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    alloc_valid = 0; store_valid = 0; chk_valid = 0;
    alloc_reg = '0; chk_reg = '0; alloc_addr = '0; store_addr = '0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rr = 0;
    // R11 outputs low while reset is held
    expect_eq("R11", "rsp bits in reset", {rsp_valid, rsp_hit, rsp_fixup}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // want: -1 no directed expectation, 1 hit, 2 fixup.
  task automatic op(input bit av, input int ar, input longint unsigned aa,
                    input bit sv, input longint unsigned sa,
                    input bit cv, input int cr, input int want, input string req);
    int hit_i, slot;
    bit e_h, e_f;
    alloc_valid = av; alloc_reg = ar[6:0]; alloc_addr = aa;
    store_valid = sv; store_addr = sa;
    chk_valid = cv; chk_reg = cr[6:0];
    @(posedge clk);
    hit_i = -1;
    if (cv) for (int i = 0; i < N; i++) if (m_v[i] && m_r[i] == cr) hit_i = i;
    slot = -1;
    if (av) begin
      for (int i = 0; i < N; i++) if (m_v[i] && m_r[i] == ar) slot = i;
      if (slot < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
    end
    if (sv) for (int i = 0; i < N; i++) if (m_v[i] && (m_a[i] >> 3) == (sa >> 3)) m_v[i] = 0;
    if (hit_i >= 0) m_v[hit_i] = 0;
    if (av) begin m_v[slot] = 1; m_r[slot] = ar; m_a[slot] = aa; end
    e_h = cv && hit_i >= 0;
    e_f = cv && hit_i < 0;
    @(negedge clk);
    expect_eq(req, "rsp {valid,hit,fixup} vs model", {rsp_valid, rsp_hit, rsp_fixup}, {cv, e_h, e_f});
    if (want == 1) expect_eq(req, "directed hit", {rsp_hit, rsp_fixup}, 2'b10);
    if (want == 2) expect_eq(req, "directed fixup", {rsp_hit, rsp_fixup}, 2'b01);
    alloc_valid = 0; store_valid = 0; chk_valid = 0;
  endtask

  task automatic alloc(input int r, input longint unsigned a, input string req);
    op(1, r, a, 0, 0, 0, 0, -1, req);
  endtask
  task automatic store(input longint unsigned a, input string req);
    op(0, 0, 0, 1, a, 0, 0, -1, req);
  endtask
  task automatic check(input int r, input int want, input string req);
    op(0, 0, 0, 0, 0, 1, r, want, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    check(5, 2, "R11 empty after reset, R5 absent entry");

    // R1 record then hit, R6 hit consumes
    alloc(10, 64'h1000, "R1");
    check(10, 1, "R1");
    check(10, 2, "R6");

    // R2 alias inside a doubleword, R10 neighbour unaffected
    alloc(11, 64'h2000, "R2");
    alloc(12, 64'h2008, "R10");
    store(64'h2004, "R2");
    check(11, 2, "R2 byte alias R10");
    check(12, 1, "R10 adjacent doubleword kept");

    // R3 overwrite the address of an existing entry
    alloc(13, 64'h3000, "R3");
    alloc(13, 64'h4000, "R3");
    store(64'h3000, "R3");
    check(13, 1, "R3 old address dropped");
    alloc(13, 64'h4000, "R3");
    store(64'h4007, "R3");
    check(13, 2, "R3 new address snooped");

    // R8 same-cycle allocate and store, allocate wins
    op(1, 14, 64'h5000, 1, 64'h5000, 0, 0, -1, "R8");
    check(14, 1, "R8 allocate kept");

    // R9 same-cycle store does not affect check
    alloc(15, 64'h6000, "R9");
    op(0, 0, 0, 1, 64'h6000, 1, 15, 1, "R9 store same cycle");
    op(1, 16, 64'h7000, 0, 0, 1, 16, 2, "R9 alloc same cycle");
    check(16, 1, "R9 alloc visible next cycle");

    // R7 fill, then rotating eviction from slot 0
    do_reset();
    for (int i = 0; i < N; i++) alloc(32 + i, 64'h10000 + 64'(i) * 64, "R7");
    alloc(48, 64'h20000, "R7");
    alloc(49, 64'h20040, "R7");
    check(32, 2, "R7 slot 0 evicted");
    check(33, 2, "R7 slot 1 evicted");
    check(34, 1, "R7 slot 2 kept");
    check(48, 1, "R7 new entry present");
    alloc(50, 64'h20080, "R7 lowest free slot");
    check(50, 1, "R7");

    // Mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      op($urandom_range(0, 1), 64 + $urandom_range(0, 5), 64'h8000 + 64'($urandom_range(0, 7)) * 4,
         $urandom_range(0, 2) == 0, 64'h8000 + 64'($urandom_range(0, 7)) * 4,
         $urandom_range(0, 1), 64 + $urandom_range(0, 5), -1, "R9 mixed R2 R3 R6");
    end
    for (int k = 0; k < 300; k++) begin
      op($urandom_range(0, 3) != 0, $urandom_range(0, 40), 64'($urandom_range(0, 63)) * 8,
         $urandom_range(0, 3) == 0, 64'($urandom_range(0, 63)) * 8,
         $urandom_range(0, 1), $urandom_range(0, 40), -1, "R7 mixed eviction");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule